// File: doc/BRIEF.md
# AAL1 Cell Payload Formatter

This block assembles the 48-byte payload of an AAL1 cell. Each cell begins with a protected sequence-number byte. After that byte come bytes taken from a valid/ready user byte stream. In structured mode, the cells with an even sequence count may carry one extra pointer byte, which leaves 46 user bytes in that cell instead of 47. A channel can also run in partial-fill mode. In that mode only a chosen number of user bytes is copied, and the rest of the payload is filled with a configurable padding byte.

A cell is requested with `cellValid` while `cellReady` is high. The request carries the channel number, the structured flag, the pointer request and its value, and the partial-fill settings. The block keeps a 3-bit sequence counter for each channel. It then emits exactly 48 bytes on `outData`, with `outLast` marking the final byte. The user stream is held off while the block emits header, pointer and padding bytes.

Top module: `aal1_payload_fmt`

## Requirements
- R1: Every accepted cell produces exactly 48 bytes with `outValid` high, and `outLast` is high on the 48th byte only. `cellReady` is high only between cells, and no byte is emitted while it is high.
- R2: The first byte of a cell has this layout. Bit 7 is the CSI flag and bits 6:4 are the sequence count. Bits 3:1 are the remainder of {CSI, count}·x^3 divided by x^3+x+1, with CSI as the most significant message bit. Bit 0 makes the parity of the whole byte even.
- R3: Each channel has its own sequence count. It is 0 after reset, goes up by one when a cell of that channel completes, and wraps from 7 to 0. A cell on one channel leaves the other channels' counts unchanged.
- R4: A pointer byte is inserted as the second byte when the cell is structured, a pointer is requested and the current count is even. Its bits 6:0 carry the pointer value (0 to 93), and bit 7 gives the byte even parity. CSI is 1 in exactly these cells.
- R5: A pointer request has no effect in an unstructured cell or when the count is odd. Such a cell has CSI 0 and no pointer byte, and it carries 47 user bytes.
- R6: User bytes follow the header (and the pointer, if present) in input order and unchanged. A cell holds 46 of them with a pointer and 47 without.
- R7: With partial fill on, the cell copies min(fill count, capacity) user bytes, and all later payload bytes are padding. The input stream is not consumed for padding bytes.
- R8: The padding value is 0x00 after reset and is replaced by `padData` on any cycle with `padWe` high.
- R9: `inReady` is low while the header, pointer or padding bytes are emitted and while the block is idle.
- R10: After reset `cellReady` is 1 while `outValid`, `outLast` and `inReady` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cellValid | input | 1 | Cell request |
| cellReady | output | 1 | Idle, request accepted |
| cellChan | input | CHAN_W | Channel of the requested cell |
| cellStruct | input | 1 | Structured format |
| cellPtrReq | input | 1 | Pointer wanted in this cell |
| cellPtr | input | 7 | Pointer value, 0 to 93 |
| cellPartial | input | 1 | Partial-fill mode for this channel |
| cellFill | input | 6 | Valid user byte count in partial fill |
| padWe | input | 1 | Load padding value |
| padData | input | 8 | New padding value |
| inValid | input | 1 | User byte valid |
| inReady | output | 1 | User byte taken |
| inData | input | 8 | User byte |
| outValid | output | 1 | Payload byte valid |
| outData | output | 8 | Payload byte |
| outLast | output | 1 | Final payload byte of the cell |

## Verification
The assertions are checked on every cycle. They cover the 48-beat framing and the position of `outLast`. They check that each header byte forms a valid CRC codeword with even parity and that CSI appears only with an even count. They also cover pointer-byte parity, pass-through of every accepted user byte, and the hold-off of the input while the header is emitted and while the block is idle. The bench scenarios cover the rest. These include the per-channel count sequence and its wrap, the independence of the channels, the ignored pointer requests, clamping of the fill count, and the exact padding value before and after it is reloaded. Each of these needs a model of the past cells.

// File: rtl/aal1_fmt_pkg.sv
package aal1_fmt_pkg;

  localparam int PAYLOAD_BYTES = 48;
  localparam int CNT_W         = 6;
  localparam logic [CNT_W-1:0] CAP_PLAIN = CNT_W'(PAYLOAD_BYTES - 1);
  localparam logic [CNT_W-1:0] CAP_PTR   = CNT_W'(PAYLOAD_BYTES - 2);
  localparam logic [6:0] PTR_LIMIT = 7'd93;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PTR,
    ST_USER
  } fmtState_e;

  typedef struct packed {
    logic load;
    logic emitHdr;
    logic emitPtr;
    logic emitUser;
    logic emitPad;
    logic cellDone;
  } fmtStrobe_t;

  // serial CRC-3, generator x^3+x+1, message MSB first
  function automatic logic [2:0] snCrc3(input logic [3:0] msg);
    logic [2:0] rem;
    logic fb;
    rem = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      fb  = msg[i] ^ rem[2];
      rem = {rem[1], rem[0] ^ fb, fb};
    end
    return rem;
  endfunction

  function automatic logic [7:0] snHeader(input logic csi, input logic [2:0] sn);
    logic [6:0] upper;
    upper = {csi, sn, snCrc3({csi, sn})};
    return {upper, ^upper};
  endfunction

endpackage

// File: rtl/aal1_fmt_ctrl.sv
module aal1_fmt_ctrl
  import aal1_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cellValid,
  input  logic             inValid,
  input  logic             hasPtr,
  input  logic [CNT_W-1:0] fillLen,
  input  logic [CNT_W-1:0] userCap,
  output fmtStrobe_t       strobe,
  output logic             cellReady,
  output logic             byteValid
);

  fmtState_e state, stateNext;
  logic [CNT_W-1:0] userIdx;
  logic advance;

  always_comb begin
    strobe  = '0;
    advance = 1'b0;
    case (state)
      ST_IDLE: strobe.load    = cellValid;
      ST_HDR:  strobe.emitHdr = 1'b1;
      ST_PTR:  strobe.emitPtr = 1'b1;
      ST_USER: begin
        if (userIdx < fillLen) strobe.emitUser = 1'b1;
        else                   strobe.emitPad  = 1'b1;
        advance = strobe.emitPad | (strobe.emitUser & inValid);
        strobe.cellDone = advance && (userIdx == userCap - CNT_W'(1));
      end
      default: ;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (cellValid) stateNext = ST_HDR;
      ST_HDR:  stateNext = hasPtr ? ST_PTR : ST_USER;
      ST_PTR:  stateNext = ST_USER;
      ST_USER: if (strobe.cellDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      userIdx <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_HDR)  userIdx <= '0;
      else if (advance)     userIdx <= userIdx + CNT_W'(1);
    end
  end

  assign cellReady = (state == ST_IDLE);
  assign byteValid = strobe.emitHdr | strobe.emitPtr | strobe.emitPad |
                     (strobe.emitUser & inValid);

endmodule

// File: rtl/aal1_fmt_dpath.sv
module aal1_fmt_dpath
  import aal1_fmt_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int CHAN_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobe_t        strobe,
  input  logic [CHAN_W-1:0] cellChan,
  input  logic              cellStruct,
  input  logic              cellPtrReq,
  input  logic [6:0]        cellPtr,
  input  logic              cellPartial,
  input  logic [CNT_W-1:0]  cellFill,
  input  logic              padWe,
  input  logic [7:0]        padData,
  input  logic [7:0]        inData,
  output logic              hasPtr,
  output logic [CNT_W-1:0]  fillLen,
  output logic [CNT_W-1:0]  userCap,
  output logic [7:0]        outData
);

  logic [2:0]        snTab [NUM_CHAN];
  logic [CHAN_W-1:0] chanQ;
  logic [7:0]        hdrQ, ptrByteQ, padQ;
  logic [2:0]        snNow;
  logic              ptrNow;
  logic [CNT_W-1:0]  capNow, fillNow;

  // one sequence counter per channel
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_sn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        snTab[c] <= 3'd0;
      else if (strobe.cellDone && chanQ == CHAN_W'(c))
        snTab[c] <= snTab[c] + 3'd1;
    end
  end

  assign snNow   = snTab[cellChan];
  assign ptrNow  = cellStruct & cellPtrReq & ~snNow[0];
  assign capNow  = ptrNow ? CAP_PTR : CAP_PLAIN;
  assign fillNow = !cellPartial        ? capNow :
                   (cellFill < capNow) ? cellFill : capNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ    <= '0;
      hasPtr   <= 1'b0;
      fillLen  <= '0;
      userCap  <= CAP_PLAIN;
      hdrQ     <= 8'h00;
      ptrByteQ <= 8'h00;
    end else if (strobe.load) begin
      chanQ    <= cellChan;
      hasPtr   <= ptrNow;
      fillLen  <= fillNow;
      userCap  <= capNow;
      hdrQ     <= snHeader(ptrNow, snNow);
      ptrByteQ <= {^cellPtr, cellPtr};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      padQ <= 8'h00;
    else if (padWe) padQ <= padData;
  end

  always_comb begin
    outData = 8'h00;
    if (strobe.emitHdr)       outData = hdrQ;
    else if (strobe.emitPtr)  outData = ptrByteQ;
    else if (strobe.emitUser) outData = inData;
    else if (strobe.emitPad)  outData = padQ;
  end

endmodule

// File: rtl/aal1_payload_fmt.sv
module aal1_payload_fmt
  import aal1_fmt_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int CHAN_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cellValid,
  output logic              cellReady,
  input  logic [CHAN_W-1:0] cellChan,
  input  logic              cellStruct,
  input  logic              cellPtrReq,
  input  logic [6:0]        cellPtr,
  input  logic              cellPartial,
  input  logic [5:0]        cellFill,
  input  logic              padWe,
  input  logic [7:0]        padData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              outLast
);

  fmtStrobe_t       strobe;
  logic             hasPtr;
  logic [CNT_W-1:0] fillLen, userCap;

  aal1_fmt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cellValid (cellValid),
    .inValid   (inValid),
    .hasPtr    (hasPtr),
    .fillLen   (fillLen),
    .userCap   (userCap),
    .strobe    (strobe),
    .cellReady (cellReady),
    .byteValid (outValid)
  );

  aal1_fmt_dpath #(
    .NUM_CHAN (NUM_CHAN),
    .CHAN_W   (CHAN_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cellChan    (cellChan),
    .cellStruct  (cellStruct),
    .cellPtrReq  (cellPtrReq),
    .cellPtr     (cellPtr),
    .cellPartial (cellPartial),
    .cellFill    (cellFill),
    .padWe       (padWe),
    .padData     (padData),
    .inData      (inData),
    .hasPtr      (hasPtr),
    .fillLen     (fillLen),
    .userCap     (userCap),
    .outData     (outData)
  );

  assign inReady = strobe.emitUser;
  assign outLast = strobe.cellDone;

endmodule

// File: rtl/aal1_fmt_checker.sv
module aal1_fmt_checker #(
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cellValid,
  input logic              cellReady,
  input logic [CHAN_W-1:0] cellChan,
  input logic              cellStruct,
  input logic              cellPtrReq,
  input logic [6:0]        cellPtr,
  input logic              inValid,
  input logic              inReady,
  input logic [7:0]        inData,
  input logic              outValid,
  input logic [7:0]        outData,
  input logic              outLast
);

  logic [5:0] beatCnt;
  logic       csiSeen;

  // codeword check: {csi,sn,crc} must divide evenly by 1011
  function automatic logic codeOk(input logic [6:0] word);
    logic [6:0] v;
    v = word;
    for (int b = 6; b >= 3; b--)
      if (v[b]) v = v ^ (7'b0001011 << (b - 3));
    return v[2:0] == 3'b000;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt <= '0;
      csiSeen <= 1'b0;
    end else if (outValid) begin
      beatCnt <= outLast ? 6'd0 : beatCnt + 6'd1;
      if (beatCnt == 6'd0) csiSeen <= outData[7];
    end
  end

  AST_LAST_ON_48: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLast |-> beatCnt == 6'd47); // R1
  AST_48_HAS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatCnt == 6'd47 |-> outLast); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cellReady |-> !outValid && !inReady && beatCnt == 6'd0); // R1
  AST_HDR_CODEWORD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatCnt == 6'd0 |-> codeOk(outData[7:1]) && !(^outData)); // R2
  AST_CSI_EVEN_SN: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatCnt == 6'd0 && outData[7] |-> !outData[4]); // R4
  AST_PTR_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatCnt == 6'd1 && csiSeen |-> !(^outData)); // R4
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cellValid && cellReady && cellStruct && cellPtrReq |-> cellPtr <= 7'd93); // R4
  AST_USER_PASS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |-> outValid && outData == inData); // R6
  AST_HDR_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatCnt == 6'd0 |-> !inReady); // R9

endmodule

bind aal1_payload_fmt aal1_fmt_checker #(.CHAN_W(CHAN_W)) u_fmtChecker (
  .clk        (clk),
  .rstN       (rstN),
  .cellValid  (cellValid),
  .cellReady  (cellReady),
  .cellChan   (cellChan),
  .cellStruct (cellStruct),
  .cellPtrReq (cellPtrReq),
  .cellPtr    (cellPtr),
  .inValid    (inValid),
  .inReady    (inReady),
  .inData     (inData),
  .outValid   (outValid),
  .outData    (outData),
  .outLast    (outLast)
);

// File: tb/test_aal1_payload_fmt.sv
`timescale 1ns/1ps
module test_aal1_payload_fmt;

  localparam int NUM_CHAN = 8;
  localparam int CHAN_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cellValid = 1'b0, cellStruct = 1'b0, cellPtrReq = 1'b0, cellPartial = 1'b0;
  logic [CHAN_W-1:0] cellChan = '0;
  logic [6:0] cellPtr = '0;
  logic [5:0] cellFill = '0;
  logic padWe = 1'b0;
  logic [7:0] padData = 8'h00;
  logic inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic cellReady, inReady, outValid, outLast;
  logic [7:0] outData;

  int checks = 0;
  int fails  = 0;
  int snModel [NUM_CHAN];
  logic [7:0] padModel = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aal1_payload_fmt #(.NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)) i_aal1_payload_fmt (
    .clk(clk), .rstN(rstN), .cellValid(cellValid), .cellReady(cellReady),
    .cellChan(cellChan), .cellStruct(cellStruct), .cellPtrReq(cellPtrReq),
    .cellPtr(cellPtr), .cellPartial(cellPartial), .cellFill(cellFill),
    .padWe(padWe), .padData(padData), .inValid(inValid), .inReady(inReady),
    .inData(inData), .outValid(outValid), .outData(outData), .outLast(outLast)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expHdr(input bit csi, input int sn);
    logic [6:0] v;
    logic [6:0] seven;
    v = {csi, 3'(sn), 3'b000};
    for (int b = 6; b >= 3; b--)
      if (v[b]) v = v ^ (7'(11) << (b - 3));
    seven = {csi, 3'(sn), v[2:0]};
    return {seven, ^seven};
  endfunction

  function automatic logic [7:0] userByte(input int ch, input int i);
    return 8'((ch * 53 + i * 7 + 11) & 255);
  endfunction

  // one cell: drive request, feed stream (stall every stallEvery cycles), compare
  task automatic runCell(input int ch, input bit st, input bit pr, input int ptr,
                         input bit pf, input int vc, input int stallEvery, input string req);
    logic [7:0] got [64];
    logic [7:0] expB [48];
    int n = 0, lastAt = -1, feed = 0, cyc = 0, pos, cap, fill, sn;
    bit withPtr, okAll;
    int badIdx, badAct, badExp;
    sn = snModel[ch];
    withPtr = st && pr && (sn % 2 == 0);
    cap = withPtr ? 46 : 47;
    fill = pf ? ((vc < cap) ? vc : cap) : cap;
    expB[0] = expHdr(withPtr, sn);
    pos = 1;
    if (withPtr) begin expB[1] = {^7'(ptr), 7'(ptr)}; pos = 2; end
    for (int i = 0; i < cap; i++) expB[pos + i] = (i < fill) ? userByte(ch, i) : padModel;

    @(negedge clk);
    cellValid = 1'b1; cellChan = CHAN_W'(ch); cellStruct = st; cellPtrReq = pr;
    cellPtr = 7'(ptr); cellPartial = pf; cellFill = 6'(vc);
    #1;
    chk(cellReady == 1'b1, "R1", "cellReady before request", int'(cellReady), 1);
    while (lastAt < 0 && cyc < 300) begin
      @(negedge clk);
      cellValid = 1'b0;
      inValid = (stallEvery == 0) || (cyc % stallEvery != 0);
      inData = (feed < fill) ? userByte(ch, feed) : 8'hEE;
      #1;
      if (inReady && inValid) feed++;
      if (outValid) begin
        if (n < 64) got[n] = outData;
        if (outLast) lastAt = n;
        n++;
      end
      cyc++;
    end
    @(negedge clk);
    inValid = 1'b0;
    chk(n == 48 && lastAt == 47, "R1", "bytes in cell / last position", n * 256 + lastAt, 48 * 256 + 47);
    if (n >= 48) begin
      chk(got[0] == expB[0], withPtr ? "R4" : req, "header byte (R2 R3)", got[0], expB[0]);
      if (withPtr) chk(got[1] == expB[1], "R4", "pointer byte", got[1], expB[1]);
      okAll = 1'b1; badIdx = 0; badAct = 0; badExp = 0;
      for (int i = pos; i < 48; i++)
        if (okAll && got[i] !== expB[i]) begin
          okAll = 1'b0; badIdx = i; badAct = got[i]; badExp = expB[i];
        end
      chk(okAll, pf ? "R7" : "R6", $sformatf("payload byte %0d", badIdx), badAct, badExp);
    end
    chk(feed == fill, "R7", "user bytes consumed (R9)", feed, fill);
    snModel[ch] = (snModel[ch] + 1) % 8;
  endtask

  task automatic testReset();
    #1;
    chk(cellReady == 1'b1, "R10", "cellReady in reset", int'(cellReady), 1);
    chk(outValid == 1'b0 && outLast == 1'b0, "R10", "outValid/outLast in reset",
        int'({outValid, outLast}), 0);
    chk(inReady == 1'b0, "R10", "inReady in reset", int'(inReady), 0);
  endtask

  task automatic testPlainCells();
    runCell(0, 0, 0, 0, 0, 0, 0, "R3");
    runCell(0, 0, 0, 0, 0, 0, 3, "R3");
    runCell(0, 0, 1, 5, 0, 0, 0, "R5");  // pointer ignored when unstructured
  endtask

  task automatic testStructured();
    runCell(1, 1, 1, 93, 0, 0, 0, "R4");
    runCell(1, 1, 1, 10, 0, 0, 4, "R5");  // odd count: no pointer
    runCell(1, 1, 1, 0, 0, 0, 0, "R4");
    runCell(1, 1, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic testPartialFill();
    runCell(2, 0, 0, 0, 1, 10, 2, "R7");
    @(negedge clk); padWe = 1'b1; padData = 8'hA5;
    @(negedge clk); padWe = 1'b0; padModel = 8'hA5;
    runCell(2, 0, 0, 0, 1, 0, 0, "R8");
    runCell(2, 1, 1, 40, 1, 5, 0, "R8");
    runCell(2, 0, 0, 0, 1, 60, 0, "R7");  // count above capacity clamps
  endtask

  task automatic testWrapAndIsolation();
    for (int k = 0; k < 9; k++) runCell(3, 1, 1, k * 9, 0, 0, 0, "R3");
    runCell(0, 0, 0, 0, 0, 0, 0, "R3");    // channel 0 continues at its own count
    runCell(5, 0, 0, 0, 0, 0, 0, "R3");    // untouched channel still at 0
  endtask

  initial begin
    for (int c = 0; c < NUM_CHAN; c++) snModel[c] = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testPlainCells();
    testStructured();
    testPartialFill();
    testWrapAndIsolation();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule